// File: doc/BRIEF.md
# Bus takeover trap controller

This block watches a main processor for conditions that need an auxiliary processor to step in. The conditions are three bus error lines (write-protect violation, no-execute violation, access to an unmapped page), an external trigger line, and the main processor's opcode-fetch sync signal, which is used for single-step tracing. Each source has its own enable bit. When an enabled source is active, the block halts the main processor and then gives the shared bus to the auxiliary processor.

The handover takes two steps. First the main ready line drops. One cycle later the auxiliary ready line rises, together with the bus-owner select that steers the bus drivers. When the auxiliary processor has finished its handler, it writes to a release register. Bus ownership then returns to the main side, and the main processor is freed one cycle after that. Each source also sets a sticky flag, and the flags are cleared by the release write. If an error line is still active when control returns, the trap fires again at once.

Both processors reach the registers through one simple access port. The registers sit in a 16-byte I/O window, and a strap input selects one of two base addresses for it. The control register also drives an interrupt request line to the main processor.

Top module: `bus_trap_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, all flags are clear, main_rdy is 1, aux_rdy and aux_owns_bus are 0, and main_irq is 0.
- R2: The control register at offset 4 can be written and read back. Its layout is: bit0 write-protect enable, bit1 no-execute enable, bit2 unmapped enable, bit3 external enable, bit4 step enable, bit6 interrupt request. Bits 5 and 7 always read 0.
- R3: The window base is 0x850 when base_sel is 0 and 0x870 when base_sel is 1. The offset is address bits [2:0], so offsets 8 to 15 of the window alias 0 to 7. Accesses outside the window have no effect.
- R4: The status register at offset 5 reads as follows: bits 0 to 3 are the flags for write-protect, no-execute, unmapped and external, bit4 is the step flag, bit5 is always 1, bit6 is the live bus_irq level and bit7 is the live bus_nmi level. Read data appears on rd_data the cycle after the read is sampled.
- R5: A flag is set only when its source is active while its enable bit is set. A flag stays set after the source goes away, until the next release write. An active source whose enable bit is clear neither sets its flag nor halts the main processor.
- R6: A trace step fires when main_sync is high while the step enable bit is set. When the step enable bit is clear, main_sync has no effect.
- R7: When an enabled source is sampled while the main processor owns the bus, main_rdy drops after that clock edge. aux_rdy and aux_owns_bus rise one cycle later. main_rdy and aux_rdy are never both high.
- R8: A write with any data to offset 7 clears all flags. If the auxiliary processor holds the bus, aux_owns_bus and aux_rdy drop after that edge and main_rdy rises one cycle later. A release write while the main processor owns the bus leaves ownership unchanged.
- R9: If an enabled source is still active when control returns, main_rdy drops again on the first cycle after it rose, and the auxiliary processor takes the bus again.
- R10: main_irq equals bit 6 of the control register, and changes on the edge that writes that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 1 | Strap: 0 selects window base 0x850, 1 selects 0x870 |
| acc_sel | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (12) | Access address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| err_wprot | input | 1 | Write-protect error line |
| err_noexec | input | 1 | No-execute error line |
| err_unmapped | input | 1 | Unmapped-page error line |
| ext_trig | input | 1 | External trigger line |
| main_sync | input | 1 | Main processor opcode-fetch marker |
| bus_irq | input | 1 | Live bus interrupt request level |
| bus_nmi | input | 1 | Live bus non-maskable interrupt level |
| main_rdy | output | 1 | Ready to the main processor (0 halts it) |
| aux_rdy | output | 1 | Ready to the auxiliary processor |
| aux_owns_bus | output | 1 | Bus driver select, 1 = auxiliary side |
| main_irq | output | 1 | Interrupt request to the main processor |

## Verification
The handover is triggered from each of the five sources in turn, so that a wrong mapping between enable bit, source line and status bit shows up in the status value. A one-cycle pulse is used to show that the flags are sticky, and a line held active across the release is used to show the immediate retrigger and the order of ready and ownership on the way back. Sources applied with their enable clear, sync applied with stepping disabled, and a release write while the main processor owns the bus each show that the sequencer does not react when it must not. Accesses through the wrong base, through the aliased upper half of the window and through the alternate strap setting check the window decode.

// File: rtl/btc_pkg.sv
package btc_pkg;
  localparam int DATA_W      = 8;
  localparam int OFS_W       = 3;
  localparam int NUM_SRC     = 5;
  localparam logic [OFS_W-1:0] OFS_CTRL    = 3'd4;
  localparam logic [OFS_W-1:0] OFS_STAT    = 3'd5;
  localparam logic [OFS_W-1:0] OFS_RELEASE = 3'd7;
  localparam int CTRL_IRQ_BIT = 6;
  localparam logic [DATA_W-1:0] CTRL_MASK = 8'h5F;

  typedef enum logic [1:0] {
    OWN_MAIN = 2'd0,
    OWN_HALT = 2'd1,
    OWN_AUX  = 2'd2,
    OWN_RET  = 2'd3
  } own_state_e;
endpackage

// File: rtl/btc_regs.sv
module btc_regs
  import btc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_LO = 12'h850,
  parameter logic [ADDR_W-1:0] BASE_HI = 12'h870
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_sel,
  input  logic              acc_sel,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              release_pulse,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WIN_LSB = 4;

  logic [ADDR_W-1:0] base_addr;
  logic              win_hit;
  logic [OFS_W-1:0]  ofs;
  logic              wr_hit;
  logic              rd_hit;
  logic [DATA_W-1:0] rd_mux;

  assign base_addr = base_sel ? BASE_HI : BASE_LO;
  assign win_hit   = acc_sel && (acc_addr[ADDR_W-1:WIN_LSB] == base_addr[ADDR_W-1:WIN_LSB]);
  assign ofs       = acc_addr[OFS_W-1:0];
  assign wr_hit    = win_hit && acc_wr;
  assign rd_hit    = win_hit && !acc_wr;
  assign release_pulse = wr_hit && (ofs == OFS_RELEASE);

  always_comb begin
    case (ofs)
      OFS_CTRL: rd_mux = ctrl_q;
      OFS_STAT: rd_mux = status_in;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      rd_data <= '0;
    end else begin
      if (wr_hit && (ofs == OFS_CTRL)) ctrl_q <= acc_wdata & CTRL_MASK;
      if (rd_hit) rd_data <= rd_mux;
    end
  end

  AST_NO_WRITE_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    !win_hit |=> $stable(ctrl_q)); // R3
endmodule

// File: rtl/btc_flags.sv
module btc_flags
  import btc_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] en,
  input  logic         clr,
  output logic [N-1:0] flags_q,
  output logic         trig
);
  logic [N-1:0] hit;
  assign hit  = cond & en;
  assign trig = |hit;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr) flags_q[i] <= 1'b0;
      else if (hit[i]) flags_q[i] <= 1'b1;
    end

    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
      $rose(flags_q[i]) |-> $past(en[i] && cond[i])); // R5
  end

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (flags_q == '0)); // R8
endmodule

// File: rtl/btc_seq.sv
module btc_seq
  import btc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic release_pulse,
  output logic main_rdy,
  output logic aux_rdy,
  output logic aux_owns_bus
);
  own_state_e state_q, state_d;
  logic main_rdy_q, aux_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      OWN_MAIN: if (trig) state_d = OWN_HALT;
      OWN_HALT: state_d = OWN_AUX;
      OWN_AUX:  if (release_pulse) state_d = OWN_RET;
      OWN_RET:  state_d = OWN_MAIN;
      default:  state_d = OWN_MAIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= OWN_MAIN;
      main_rdy_q <= 1'b1;
      aux_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      main_rdy_q <= (state_d == OWN_MAIN);
      aux_q      <= (state_d == OWN_AUX);
    end
  end

  assign main_rdy     = main_rdy_q;
  assign aux_rdy      = aux_q;
  assign aux_owns_bus = aux_q;

  AST_TRAP_HALTS: assert property (@(posedge clk) disable iff (rst)
    (state_q == OWN_MAIN && trig) |=> !main_rdy); // R7
  AST_HALT_BEFORE_AUX: assert property (@(posedge clk) disable iff (rst)
    $rose(aux_owns_bus) |-> $past(!main_rdy)); // R7
  AST_NEVER_BOTH_RDY: assert property (@(posedge clk) disable iff (rst)
    !(main_rdy && aux_rdy)); // R7
  AST_BUS_BACK_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(main_rdy) |-> (!aux_owns_bus && $past(!aux_owns_bus))); // R8
endmodule

// File: rtl/bus_trap_ctrl.sv
module bus_trap_ctrl
  import btc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_LO = 12'h850,
  parameter logic [ADDR_W-1:0] BASE_HI = 12'h870
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_sel,
  input  logic              acc_sel,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        rd_data,
  input  logic              err_wprot,
  input  logic              err_noexec,
  input  logic              err_unmapped,
  input  logic              ext_trig,
  input  logic              main_sync,
  input  logic              bus_irq,
  input  logic              bus_nmi,
  output logic              main_rdy,
  output logic              aux_rdy,
  output logic              aux_owns_bus,
  output logic              main_irq
);
  logic [DATA_W-1:0]  ctrl_q;
  logic [DATA_W-1:0]  status;
  logic [NUM_SRC-1:0] cond;
  logic [NUM_SRC-1:0] flags;
  logic               release_pulse;
  logic               trig;

  assign cond   = {main_sync, ext_trig, err_unmapped, err_noexec, err_wprot};
  assign status = {bus_nmi, bus_irq, 1'b1, flags};

  btc_regs #(.ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_regs (
    .clk(clk), .rst(rst), .base_sel(base_sel),
    .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .status_in(status), .ctrl_q(ctrl_q), .release_pulse(release_pulse),
    .rd_data(rd_data)
  );

  btc_flags #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst(rst), .cond(cond), .en(ctrl_q[NUM_SRC-1:0]),
    .clr(release_pulse), .flags_q(flags), .trig(trig)
  );

  btc_seq u_seq (
    .clk(clk), .rst(rst), .trig(trig), .release_pulse(release_pulse),
    .main_rdy(main_rdy), .aux_rdy(aux_rdy), .aux_owns_bus(aux_owns_bus)
  );

  assign main_irq = ctrl_q[CTRL_IRQ_BIT];
endmodule

// File: tb/bus_trap_ctrl_tb_top.sv
module bus_trap_ctrl_tb_top;
  localparam int CLK_NS = 10;
  localparam int WD_CYC = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic base_sel = 1'b0;
  logic acc_sel = 1'b0, acc_wr = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] rd_data;
  logic err_wprot = 0, err_noexec = 0, err_unmapped = 0, ext_trig = 0, main_sync = 0;
  logic bus_irq = 0, bus_nmi = 0;
  logic main_rdy, aux_rdy, aux_owns_bus, main_irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic rd_d = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  bus_trap_ctrl dut_i (
    .clk(clk), .rst(rst), .base_sel(base_sel), .acc_sel(acc_sel), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .err_wprot(err_wprot), .err_noexec(err_noexec), .err_unmapped(err_unmapped),
    .ext_trig(ext_trig), .main_sync(main_sync), .bus_irq(bus_irq), .bus_nmi(bus_nmi),
    .main_rdy(main_rdy), .aux_rdy(aux_rdy), .aux_owns_bus(aux_owns_bus), .main_irq(main_irq)
  );

  function automatic logic [11:0] base();
    return base_sel ? 12'h870 : 12'h850;
  endfunction

  always @(posedge clk) rd_d <= acc_sel && !acc_wr;

  // monitor: compares registered read data with scoreboard entries
  always @(negedge clk) begin
    if (rd_d) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL read with empty scoreboard act=%02h exp=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s read act=%02h exp=%02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic wr_abs(input logic [11:0] a, input logic [7:0] d);
    acc_sel = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_sel = 0; acc_wr = 0;
  endtask

  task automatic rd_abs(input logic [11:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    acc_sel = 1; acc_wr = 0; acc_addr = a;
    @(negedge clk);
    acc_sel = 0;
  endtask

  task automatic wr(input logic [2:0] o, input logic [7:0] d);
    wr_abs(base() + 12'(o), d);
  endtask

  task automatic rd(input logic [2:0] o, input logic [7:0] e, input string tag);
    rd_abs(base() + 12'(o), e, tag);
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: err_wprot = v;
      1: err_noexec = v;
      2: err_unmapped = v;
      3: ext_trig = v;
      default: main_sync = v;
    endcase
  endtask

  // one-cycle pulse on an enabled source, full handover and release
  task automatic do_trap(input int s, input logic [7:0] en, input logic [7:0] exp_stat, input string tag);
    wr(3'd4, en);
    set_src(s, 1'b1);
    @(negedge clk);
    set_src(s, 1'b0);
    chk({tag, " R7 main halted"}, main_rdy, 1'b0);
    chk({tag, " R7 aux still held"}, aux_rdy, 1'b0);
    @(negedge clk);
    chk({tag, " R7 aux ready"}, aux_rdy, 1'b1);
    chk({tag, " R7 aux owns bus"}, aux_owns_bus, 1'b1);
    rd(3'd5, exp_stat, {tag, " R4 R5 sticky status"});
    wr(3'd7, 8'hA5);
    chk({tag, " R8 bus back"}, aux_owns_bus, 1'b0);
    chk({tag, " R8 aux not ready"}, aux_rdy, 1'b0);
    chk({tag, " R8 main still halted"}, main_rdy, 1'b0);
    @(negedge clk);
    chk({tag, " R8 main ready"}, main_rdy, 1'b1);
    rd(3'd5, 8'h20, {tag, " R8 flags cleared"});
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 main_rdy", main_rdy, 1'b1);
    chk("R1 aux_rdy", aux_rdy, 1'b0);
    chk("R1 aux_owns_bus", aux_owns_bus, 1'b0);
    chk("R1 main_irq", main_irq, 1'b0);
    rd(3'd4, 8'h00, "R1 ctrl reset");
    rd(3'd5, 8'h20, "R1 R4 status reset");

    // R2 / R10 control register
    wr(3'd4, 8'hFF);
    chk("R10 irq set", main_irq, 1'b1);
    rd(3'd4, 8'h5F, "R2 reserved bits zero");
    wr(3'd4, 8'h00);
    chk("R10 irq clear", main_irq, 1'b0);
    rd(3'd4, 8'h00, "R2 ctrl cleared");

    // R3 window decode
    wr_abs(12'h874, 8'h01);
    rd(3'd4, 8'h00, "R3 wrong base ignored");
    base_sel = 1;
    wr(3'd4, 8'h02);
    rd(3'd4, 8'h02, "R3 alternate base");
    rd_abs(12'h87C, 8'h02, "R3 upper half alias");
    wr(3'd4, 8'h00);
    base_sel = 0;
    wr_abs(12'h84C, 8'h04);
    rd(3'd4, 8'h00, "R3 below window ignored");

    // R5 disabled sources: no flag, no halt
    err_wprot = 1; err_noexec = 1; err_unmapped = 1; ext_trig = 1;
    @(negedge clk);
    err_wprot = 0; err_noexec = 0; err_unmapped = 0; ext_trig = 0;
    chk("R5 disabled no halt", main_rdy, 1'b1);
    rd(3'd5, 8'h20, "R5 disabled no flag");

    // R6 sync with stepping disabled
    main_sync = 1;
    @(negedge clk);
    main_sync = 0;
    chk("R6 sync ignored when disabled", main_rdy, 1'b1);

    // R4 live interrupt levels
    bus_irq = 1; bus_nmi = 1;
    rd(3'd5, 8'hE0, "R4 live irq nmi");
    bus_irq = 0;
    rd(3'd5, 8'hA0, "R4 live nmi only");
    bus_nmi = 0;

    // R7 R8 each source in turn
    do_trap(0, 8'h01, 8'h21, "wprot");
    do_trap(1, 8'h02, 8'h22, "noexec");
    do_trap(2, 8'h04, 8'h24, "unmapped");
    do_trap(3, 8'h08, 8'h28, "ext");
    do_trap(4, 8'h10, 8'h30, "R6 step");

    // R8 release while main owns bus
    wr(3'd7, 8'h00);
    chk("R8 release idle keeps main", main_rdy, 1'b1);
    chk("R8 release idle no aux", aux_owns_bus, 1'b0);

    // R9 retrigger while error held
    wr(3'd4, 8'h04);
    err_unmapped = 1;
    @(negedge clk);
    chk("R9 first halt", main_rdy, 1'b0);
    @(negedge clk);
    chk("R9 first takeover", aux_owns_bus, 1'b1);
    wr(3'd7, 8'h00);
    chk("R9 bus returned", aux_owns_bus, 1'b0);
    @(negedge clk);
    chk("R9 main freed", main_rdy, 1'b1);
    @(negedge clk);
    chk("R9 halted again", main_rdy, 1'b0);
    @(negedge clk);
    chk("R9 aux again", aux_owns_bus, 1'b1);
    rd(3'd5, 8'h24, "R9 flag set again");
    err_unmapped = 0;
    wr(3'd7, 8'h00);
    @(negedge clk);
    @(negedge clk);
    chk("R9 stays with main", main_rdy, 1'b1);
    chk("R9 no further takeover", aux_owns_bus, 1'b0);
    wr(3'd4, 8'h00);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard leftover act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule